// File: doc/BRIEF.md
# Power Mode and Emulation Mode Controller

This block sequences the operating modes of a small 8-bit controller: normal running, a clock-gated idle state, a full power-down state with the oscillator stopped, an oscillator restart wait, and an on-circuit emulation state. It filters the external reset pin, accepts idle and power-down requests from the core, and decides when each mode ends. A mode ends on a recognised reset, on an enabled interrupt (idle), or on a level-sensitive external interrupt pin (power-down).

From the current mode it drives registered clock gates for the CPU, the peripherals and the counter-array timer. It also drives an oscillator enable and pin-state overrides for the address-latch and program-store strobes and for the ports. While a reset that ends idle is still being recognised, it raises an internal-RAM write inhibit. The emulation state is entered by a strobe-pin pattern held across the end of a recognised reset.

Top module: `pwrm_ctrl`

## Requirements
- R1: `cpu_rst` rises only after `rst_pin` has been high for RST_MC*CLKS_PER_MC consecutive clocks in which `osc_en` and `osc_stable` are both 1. A clock with the oscillator not running holds the count. A low `rst_pin` clears the count, and `cpu_rst` is low in the clock after `rst_pin` is seen low.
- R2: A recognised reset has priority over every other exit and request. While `cpu_rst` and `rst_pin` are high, the next cycle shows the running clock state (`cpu_clk_en`=1, `osc_en`=1), and `idle_req`/`pd_req` are ignored.
- R3: An `idle_req` seen while running enters idle in the next cycle. Idle gives `cpu_clk_en`=0, `osc_en`=1, `per_clk_en`=1, `strb_force`=1 and `strb_level`=1. Idle stays until any bit of `irq_pend` is 1, after which `cpu_clk_en`=1 the next cycle.
- R4: In idle, `ctr_clk_en` equals the inverse of `ctr_idle_stop`, where 1 means the counter-array timer pauses. In every other non-power-down mode `ctr_clk_en`=1.
- R5: A `pd_req` seen while running enters power-down. Power-down gives `osc_en`, `cpu_clk_en`, `per_clk_en` and `ctr_clk_en` all 0, with `strb_force`=1 and `strb_level`=0. `irq_pend` has no effect in power-down. A low external pin wakes nothing if its `ext_en` bit is 0 or its `ext_trig_edge` bit is 1 (1 = edge mode). A high `rst_pin` restarts the oscillator.
- R6: In power-down, a low `ext_pin_n[i]` with `ext_en[i]`=1 and `ext_trig_edge[i]`=0 sets `osc_en`=1 in the next cycle while `cpu_clk_en` stays 0. `cpu_clk_en` returns to 1 only in the cycle after `osc_stable`=1 and every such enabled level-mode pin is high.
- R7: With `ext_code`=1, `lo_port_float`=1 in idle and power-down. `hi_port_addr`=1 in idle only. With `ext_code`=0 both are 0 in those modes.
- R8: At the clock where `rst_pin` is seen low while `cpu_rst` is high, the block enters emulation only under two conditions. First, `ale_pin` is low at that clock. Second, in the recognised-reset clocks before it, `ale_pin` stayed low and was low while `psen_pin` was high. Otherwise the block runs.
- R9: In emulation, `lo_port_float`=1, `ports_weak`=1, `strb_weak`=1, `strb_force`=0, `cpu_clk_en`=0 and `osc_en`=1. Idle and power-down requests are ignored. A recognised reset released with `ale_pin` high returns to running.
- R10: A high `rst_pin` in idle restores `cpu_clk_en`=1 in the next cycle and raises `ram_wr_inh`. `ram_wr_inh` stays high until the cycle after `cpu_rst` is seen high, or until `rst_pin` is seen low.
- R11: When `pd_req` and `idle_req` are both high while running, power-down is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst | input | 1 | Synchronous active-high block reset |
| rst_pin | input | 1 | Device reset pin level |
| idle_req | input | 1 | Idle request from the core |
| pd_req | input | 1 | Power-down request from the core |
| irq_pend | input | N_IRQ | Enabled pending interrupt requests |
| ext_pin_n | input | N_EXT | External interrupt pin levels, active low |
| ext_trig_edge | input | N_EXT | 1 = edge-triggered, 0 = level-sensitive |
| ext_en | input | N_EXT | External interrupt enables |
| ale_pin | input | 1 | Address-latch strobe pin level, sampled in reset |
| psen_pin | input | 1 | Program-store strobe pin level, sampled in reset |
| osc_stable | input | 1 | Oscillator has settled |
| ext_code | input | 1 | Core fetches from external program memory |
| ctr_idle_stop | input | 1 | 1 = counter-array timer pauses in idle |
| cpu_rst | output | 1 | Recognised reset to the core |
| cpu_clk_en | output | 1 | CPU clock gate |
| osc_en | output | 1 | Oscillator enable |
| per_clk_en | output | 1 | Peripheral clock gate |
| ctr_clk_en | output | 1 | Counter-array timer clock gate |
| strb_force | output | 1 | Both strobe pins driven to `strb_level` |
| strb_level | output | 1 | Level forced on the strobes |
| strb_weak | output | 1 | Strobes weakly pulled high |
| lo_port_float | output | 1 | Low port floats |
| hi_port_addr | output | 1 | High port keeps emitting the address |
| ports_weak | output | 1 | Other ports weakly pulled high |
| ram_wr_inh | output | 1 | Internal RAM write inhibit |

## Verification
The bench builds the block with CLKS_PER_MC=2, RST_MC=2, N_IRQ=3 and N_EXT=2. These values make the reset window four clocks, so its exact edge and an interrupted pulse can be checked cycle by cycle. They also keep the idle sweep over external code and counter options, and the power-down sweep over every external line with all enable and trigger combinations, small enough to run in full. All eight strobe patterns around reset release are applied to the emulation entry.

// File: rtl/pwrm_pkg.sv
package pwrm_pkg;

  typedef enum logic [2:0] {
    M_RUN  = 3'd0,
    M_IDLE = 3'd1,
    M_PDWN = 3'd2,
    M_OSCW = 3'd3,
    M_EMU  = 3'd4
  } pm_state_e;

  typedef struct packed {
    logic cpu_clk;
    logic osc;
    logic per_clk;
    logic ctr_clk;
    logic strb_force;
    logic strb_level;
    logic strb_weak;
    logic lo_float;
    logic hi_addr;
    logic ports_weak;
  } pm_out_t;

  localparam pm_out_t PM_OUT_RUN = '{cpu_clk: 1'b1, osc: 1'b1, per_clk: 1'b1,
                                     ctr_clk: 1'b1, default: 1'b0};

endpackage

// File: rtl/pwrm_rst_filter.sv
module pwrm_rst_filter #(
  parameter int RST_CLKS = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_pin,
  input  logic osc_run,
  output logic cpu_rst
);
  localparam int CW = $clog2(RST_CLKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(RST_CLKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !rst_pin) cnt_q <= '0;
    else if (osc_run && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign cpu_rst = (cnt_q == LIMIT);

  a_r1_drop: assert property (@(posedge clk) disable iff (rst)
    !rst_pin |=> !cpu_rst);
  a_r1_rise_needs_pin: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_rst) |-> $past(rst_pin));

endmodule

// File: rtl/pwrm_wake.sv
module pwrm_wake #(
  parameter int N_EXT = 2
) (
  input  logic [N_EXT-1:0] ext_pin_n,
  input  logic [N_EXT-1:0] ext_en,
  input  logic [N_EXT-1:0] ext_trig_edge,
  output logic             wake_low
);
  logic [N_EXT-1:0] line_hit;

  for (genvar i = 0; i < N_EXT; i++) begin : g_line
    assign line_hit[i] = ext_en[i] & ~ext_trig_edge[i] & ~ext_pin_n[i];
  end

  assign wake_low = |line_hit;

endmodule

// File: rtl/pwrm_fsm.sv
module pwrm_fsm
  import pwrm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cpu_rst,
  input  logic      rst_pin,
  input  logic      ale_pin,
  input  logic      psen_pin,
  input  logic      idle_req,
  input  logic      pd_req,
  input  logic      irq_any,
  input  logic      wake_low,
  input  logic      osc_stable,
  output pm_state_e state_d,
  output logic      ram_inh
);
  pm_state_e state_q;
  logic      arm_q;

  always_comb begin
    state_d = state_q;
    if (cpu_rst) begin
      if (!rst_pin && arm_q && !ale_pin) state_d = M_EMU;
      else                               state_d = M_RUN;
    end else begin
      unique case (state_q)
        M_RUN: begin
          if (pd_req)        state_d = M_PDWN;
          else if (idle_req) state_d = M_IDLE;
        end
        M_IDLE: if (rst_pin || irq_any) state_d = M_RUN;
        M_PDWN: if (rst_pin || wake_low) state_d = M_OSCW;
        M_OSCW: if (osc_stable && !wake_low && !rst_pin) state_d = M_RUN;
        M_EMU:  state_d = M_EMU;
        default: state_d = M_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= M_RUN;
      arm_q   <= 1'b0;
      ram_inh <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cpu_rst && rst_pin) arm_q <= !ale_pin && (psen_pin || arm_q);
      else if (!cpu_rst)      arm_q <= 1'b0;
      if (state_q == M_IDLE && rst_pin && !cpu_rst) ram_inh <= 1'b1;
      else if (cpu_rst || !rst_pin)                 ram_inh <= 1'b0;
    end
  end

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q == M_IDLE && !irq_any && !rst_pin && !cpu_rst) |=> state_q == M_IDLE);
  a_r5_pd_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q == M_PDWN && !rst_pin && !wake_low && !cpu_rst) |=> state_q == M_PDWN);
  a_r10_inh_release: assert property (@(posedge clk) disable iff (rst)
    (ram_inh && cpu_rst) |=> !ram_inh);
  a_r9_emu_stays: assert property (@(posedge clk) disable iff (rst)
    (state_q == M_EMU && !cpu_rst) |=> state_q == M_EMU);

endmodule

// File: rtl/pwrm_out_dec.sv
module pwrm_out_dec
  import pwrm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pm_state_e state_d,
  input  logic      ext_code,
  input  logic      ctr_idle_stop,
  output pm_out_t   out_q
);
  pm_out_t out_d;

  always_comb begin
    out_d = PM_OUT_RUN;
    unique case (state_d)
      M_IDLE: begin
        out_d.cpu_clk    = 1'b0;
        out_d.ctr_clk    = !ctr_idle_stop;
        out_d.strb_force = 1'b1;
        out_d.strb_level = 1'b1;
        out_d.lo_float   = ext_code;
        out_d.hi_addr    = ext_code;
      end
      M_PDWN, M_OSCW: begin
        out_d.cpu_clk    = 1'b0;
        out_d.osc        = (state_d == M_OSCW);
        out_d.per_clk    = 1'b0;
        out_d.ctr_clk    = 1'b0;
        out_d.strb_force = 1'b1;
        out_d.strb_level = 1'b0;
        out_d.lo_float   = ext_code;
      end
      M_EMU: begin
        out_d.cpu_clk    = 1'b0;
        out_d.strb_weak  = 1'b1;
        out_d.lo_float   = 1'b1;
        out_d.ports_weak = 1'b1;
      end
      default: out_d = PM_OUT_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= PM_OUT_RUN;
    else     out_q <= out_d;
  end

endmodule

// File: rtl/pwrm_ctrl.sv
module pwrm_ctrl
  import pwrm_pkg::*;
#(
  parameter int CLKS_PER_MC = 12,
  parameter int RST_MC      = 2,
  parameter int N_IRQ       = 7,
  parameter int N_EXT       = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rst_pin,
  input  logic             idle_req,
  input  logic             pd_req,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_EXT-1:0] ext_pin_n,
  input  logic [N_EXT-1:0] ext_trig_edge,
  input  logic [N_EXT-1:0] ext_en,
  input  logic             ale_pin,
  input  logic             psen_pin,
  input  logic             osc_stable,
  input  logic             ext_code,
  input  logic             ctr_idle_stop,
  output logic             cpu_rst,
  output logic             cpu_clk_en,
  output logic             osc_en,
  output logic             per_clk_en,
  output logic             ctr_clk_en,
  output logic             strb_force,
  output logic             strb_level,
  output logic             strb_weak,
  output logic             lo_port_float,
  output logic             hi_port_addr,
  output logic             ports_weak,
  output logic             ram_wr_inh
);
  localparam int RST_CLKS = CLKS_PER_MC * RST_MC;

  pm_state_e state_d;
  pm_out_t   outs;
  logic      wake_low;

  pwrm_rst_filter #(.RST_CLKS(RST_CLKS)) u_filt (
    .clk(clk), .rst(rst), .rst_pin(rst_pin),
    .osc_run(outs.osc && osc_stable), .cpu_rst(cpu_rst)
  );

  pwrm_wake #(.N_EXT(N_EXT)) u_wake (
    .ext_pin_n(ext_pin_n), .ext_en(ext_en), .ext_trig_edge(ext_trig_edge),
    .wake_low(wake_low)
  );

  pwrm_fsm u_fsm (
    .clk(clk), .rst(rst), .cpu_rst(cpu_rst), .rst_pin(rst_pin),
    .ale_pin(ale_pin), .psen_pin(psen_pin), .idle_req(idle_req),
    .pd_req(pd_req), .irq_any(|irq_pend), .wake_low(wake_low),
    .osc_stable(osc_stable), .state_d(state_d), .ram_inh(ram_wr_inh)
  );

  pwrm_out_dec u_dec (
    .clk(clk), .rst(rst), .state_d(state_d), .ext_code(ext_code),
    .ctr_idle_stop(ctr_idle_stop), .out_q(outs)
  );

  assign cpu_clk_en    = outs.cpu_clk;
  assign osc_en        = outs.osc;
  assign per_clk_en    = outs.per_clk;
  assign ctr_clk_en    = outs.ctr_clk;
  assign strb_force    = outs.strb_force;
  assign strb_level    = outs.strb_level;
  assign strb_weak     = outs.strb_weak;
  assign lo_port_float = outs.lo_float;
  assign hi_port_addr  = outs.hi_addr;
  assign ports_weak    = outs.ports_weak;

  a_r2_reset_runs: assert property (@(posedge clk) disable iff (rst)
    (cpu_rst && rst_pin) |=> (cpu_clk_en && osc_en));
  a_r6_osc_before_cpu: assert property (@(posedge clk) disable iff (rst)
    $rose(osc_en) |-> !cpu_clk_en);

endmodule

// File: tb/test_pwrm_ctrl.sv
module test_pwrm_ctrl;
  localparam int NI = 3;
  localparam int NE = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rst_pin = 1'b0, idle_req = 1'b0, pd_req = 1'b0;
  logic [NI-1:0] irq_pend = '0;
  logic [NE-1:0] ext_pin_n = '1, ext_trig_edge = '0, ext_en = '0;
  logic ale_pin = 1'b1, psen_pin = 1'b1, osc_stable = 1'b1;
  logic ext_code = 1'b0, ctr_idle_stop = 1'b0;
  logic cpu_rst, cpu_clk_en, osc_en, per_clk_en, ctr_clk_en;
  logic strb_force, strb_level, strb_weak, lo_port_float, hi_port_addr, ports_weak, ram_wr_inh;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pwrm_ctrl #(.CLKS_PER_MC(2), .RST_MC(2), .N_IRQ(NI), .N_EXT(NE)) i_pwrm_ctrl (
    .clk(clk), .rst(rst), .rst_pin(rst_pin), .idle_req(idle_req), .pd_req(pd_req),
    .irq_pend(irq_pend), .ext_pin_n(ext_pin_n), .ext_trig_edge(ext_trig_edge),
    .ext_en(ext_en), .ale_pin(ale_pin), .psen_pin(psen_pin), .osc_stable(osc_stable),
    .ext_code(ext_code), .ctr_idle_stop(ctr_idle_stop), .cpu_rst(cpu_rst),
    .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .per_clk_en(per_clk_en),
    .ctr_clk_en(ctr_clk_en), .strb_force(strb_force), .strb_level(strb_level),
    .strb_weak(strb_weak), .lo_port_float(lo_port_float), .hi_port_addr(hi_port_addr),
    .ports_weak(ports_weak), .ram_wr_inh(ram_wr_inh)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_req(input logic id, input logic pd);
    idle_req = id; pd_req = pd;
    step(1);
    idle_req = 1'b0; pd_req = 1'b0;
  endtask

  task automatic plain_reset();
    ale_pin = 1'b1; psen_pin = 1'b1; rst_pin = 1'b1;
    step(10);
    rst_pin = 1'b0;
    step(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // reset state
    chk("R2 reset cpu_clk", cpu_clk_en, 1);
    chk("R2 reset osc", osc_en, 1);
    chk("R4 reset ctr", ctr_clk_en, 1);
    chk("R7 reset strb", {strb_force, strb_weak, lo_port_float, hi_port_addr, ports_weak}, 0);
    chk("R10 reset inh", ram_wr_inh, 0);
    chk("R1 reset cpu_rst", cpu_rst, 0);

    // R1 window edge
    rst_pin = 1'b1; step(3);
    chk("R1 before window", cpu_rst, 0);
    step(1);
    chk("R1 at window", cpu_rst, 1);
    rst_pin = 1'b0; step(1);
    chk("R1 release", cpu_rst, 0);
    // R1 interrupted pulse
    rst_pin = 1'b1; step(3); rst_pin = 1'b0; step(1); rst_pin = 1'b1; step(3);
    chk("R1 interrupted", cpu_rst, 0);
    step(1);
    chk("R1 restart count", cpu_rst, 1);
    rst_pin = 1'b0; step(1);
    // R1 oscillator not stable holds count
    osc_stable = 1'b0; rst_pin = 1'b1; step(10);
    chk("R1 osc not stable", cpu_rst, 0);
    osc_stable = 1'b1; step(3);
    chk("R1 after stable 3", cpu_rst, 0);
    step(1);
    chk("R1 after stable 4", cpu_rst, 1);
    // R2 requests ignored during reset
    idle_req = 1'b1; pd_req = 1'b1; step(2);
    chk("R2 req ignored cpu", cpu_clk_en, 1);
    chk("R2 req ignored osc", osc_en, 1);
    idle_req = 1'b0; pd_req = 1'b0; rst_pin = 1'b0; step(1);

    // R3 R4 R7 idle sweep
    for (int e = 0; e < 2; e++) begin
      for (int s = 0; s < 2; s++) begin
        for (int q = 0; q < NI; q++) begin
          ext_code = e[0]; ctr_idle_stop = s[0];
          pulse_req(1'b1, 1'b0);
          chk("R3 idle cpu", cpu_clk_en, 0);
          chk("R3 idle osc/per", {osc_en, per_clk_en}, 2'b11);
          chk("R3 idle strobes", {strb_force, strb_level}, 2'b11);
          chk("R4 idle ctr", ctr_clk_en, !s[0]);
          chk("R7 idle ports", {lo_port_float, hi_port_addr}, {e[0], e[0]});
          step(3);
          chk("R3 idle holds", cpu_clk_en, 0);
          irq_pend = NI'(1) << q; step(1);
          chk("R3 irq wake", cpu_clk_en, 1);
          chk("R4 run ctr", ctr_clk_en, 1);
          irq_pend = '0;
        end
      end
    end
    ext_code = 1'b0; ctr_idle_stop = 1'b0;

    // R5 R6 R7 power-down sweep
    for (int ln = 0; ln < NE; ln++) begin
      for (int cfg = 0; cfg < 4; cfg++) begin
        logic wk;
        wk = cfg[0] && !cfg[1];
        ext_en = '0; ext_trig_edge = '0;
        ext_en[ln] = cfg[0]; ext_trig_edge[ln] = cfg[1];
        ext_code = ln[0];
        pulse_req(1'b0, 1'b1);
        chk("R5 pd clocks", {osc_en, cpu_clk_en, per_clk_en, ctr_clk_en}, 0);
        chk("R5 pd strobes", {strb_force, strb_level}, 2'b10);
        chk("R7 pd ports", {lo_port_float, hi_port_addr}, {ln[0], 1'b0});
        osc_stable = 1'b0; irq_pend = '1; ext_pin_n[ln] = 1'b0;
        step(2);
        chk("R6 wake osc", osc_en, wk);
        chk("R6 wake cpu off", cpu_clk_en, 0);
        if (wk) begin
          irq_pend = '0; osc_stable = 1'b1; step(2);
          chk("R6 pin still low", cpu_clk_en, 0);
          ext_pin_n[ln] = 1'b1; step(1);
          chk("R6 exit on release", cpu_clk_en, 1);
        end else begin
          ext_pin_n[ln] = 1'b1; irq_pend = '0; osc_stable = 1'b1; step(2);
          chk("R5 no wake", osc_en, 0);
          rst_pin = 1'b1; step(1);
          chk("R5 reset restarts osc", {osc_en, cpu_clk_en}, 2'b10);
          step(8);
          chk("R5 reset exit", {cpu_rst, cpu_clk_en}, 2'b11);
          rst_pin = 1'b0; step(1);
        end
      end
    end
    ext_en = '0; ext_code = 1'b0;

    // R11 simultaneous requests
    pulse_req(1'b1, 1'b1);
    chk("R11 pd wins", {osc_en, cpu_clk_en}, 0);
    plain_reset();
    chk("R11 back to run", cpu_clk_en, 1);

    // R8 R9 emulation entry sweep
    for (int p = 0; p < 8; p++) begin
      logic emu;
      emu = !p[0] && p[1] && !p[2];
      ale_pin = p[0]; psen_pin = p[1]; rst_pin = 1'b1;
      step(6);
      ale_pin = p[2]; rst_pin = 1'b0; step(1);
      chk("R8 entry", ports_weak, emu);
      if (emu) begin
        chk("R9 emu pins", {lo_port_float, strb_weak, strb_force}, 3'b110);
        chk("R9 emu clocks", {cpu_clk_en, osc_en}, 2'b01);
        pulse_req(1'b1, 1'b0); pulse_req(1'b0, 1'b1); step(1);
        chk("R9 req ignored", {ports_weak, osc_en}, 2'b11);
        plain_reset();
        chk("R9 reset leaves", {ports_weak, cpu_clk_en}, 2'b01);
      end else begin
        chk("R8 runs", cpu_clk_en, 1);
      end
    end
    ale_pin = 1'b1; psen_pin = 1'b1;

    // R10 RAM inhibit when reset ends idle
    pulse_req(1'b1, 1'b0);
    rst_pin = 1'b1; step(1);
    chk("R10 cpu resumes", cpu_clk_en, 1);
    chk("R10 inhibit on", ram_wr_inh, 1);
    step(3);
    chk("R10 inhibit at recog", {ram_wr_inh, cpu_rst}, 2'b11);
    step(1);
    chk("R10 inhibit off", ram_wr_inh, 0);
    rst_pin = 1'b0; step(1);
    pulse_req(1'b1, 1'b0);
    rst_pin = 1'b1; step(2);
    chk("R10 short pulse inh", ram_wr_inh, 1);
    rst_pin = 1'b0; step(1);
    chk("R10 short pulse drop", {ram_wr_inh, cpu_rst}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule